// File: doc/BRIEF.md
# Next Program Counter Unit

This unit holds the 32-bit program counter of a simple processor core and chooses the value it takes next. A 3-bit control code selects one of five moves:

- fall through to the following instruction;
- branch if two register operands are equal;
- branch if they differ;
- jump to an absolute word index;
- jump to an address held in a register.

Branch displacements count instruction words and are measured from the address of the next instruction. An absolute jump keeps the top four bits of that address.

The surrounding pipeline presents the decoded control code, both register operands, the 16-bit displacement and the 26-bit jump index. It raises `advance_i` on every cycle in which the counter may move. Two flags are registered together with the new counter value:

- `taken_o` reports that control flow left the sequential path.
- `misalign_o` reports that a register jump loaded a target that is not word aligned.

Top module: `npc_unit`

## Requirements
- R1: While `rst_i` is high at a clock edge, `pc_o` becomes RESET_VEC (default 32'h0000_1000) and both `taken_o` and `misalign_o` become 0.
- R2: Control codes are 0 = sequential, 1 = branch-if-equal, 2 = branch-if-not-equal, 3 = absolute jump, 4 = register jump. Codes 5, 6 and 7 behave as code 0. On an advancing cycle with code 0, `pc_o` becomes `pc_o + 4` (modulo 2^32) and `taken_o` becomes 0.
- R3: On an advancing cycle with code 1, when `opa_i == opb_i`, `pc_o` becomes `(pc_o + 4) + 4 * sext(offset_i)` and `taken_o` becomes 1. When the operands differ, `pc_o` becomes `pc_o + 4` and `taken_o` becomes 0.
- R4: On an advancing cycle with code 2, when the operands differ, the counter takes the same displacement target as in R3 and `taken_o` becomes 1. When the operands are equal, `pc_o` becomes `pc_o + 4` and `taken_o` becomes 0.
- R5: On an advancing cycle with code 3, `pc_o` becomes `{(pc_o+4)[31:28], index_i, 2'b00}` and `taken_o` becomes 1.
- R6: On an advancing cycle with code 4, `pc_o` becomes `opa_i` and `taken_o` becomes 1.
- R7: On an advancing cycle with code 4 and `opa_i[1:0] != 0`, `misalign_o` becomes 1 and the target is still loaded. In every other case `misalign_o` becomes 0.
- R8: On a cycle with `advance_i` low, `pc_o` keeps its value and both flags become 0, whatever the other inputs are.
- R9: The displacement spans its full signed range: 16'h7FFF moves the counter forward and 16'h8000 moves it backward. The additions wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| advance_i | input | 1 | Allows the counter to move this cycle |
| ctrl_i | input | 3 | Control code (see R2) |
| opa_i | input | 32 | First register operand; also the register-jump target |
| opb_i | input | 32 | Second register operand for comparison |
| offset_i | input | 16 | Signed branch displacement in words |
| index_i | input | 26 | Absolute jump word index |
| pc_o | output | 32 | Current program counter |
| taken_o | output | 1 | Control flow left the sequential path on the last advance |
| misalign_o | output | 1 | Last advance loaded a register target with nonzero low bits |

## Verification
The hardest states to reach are the counter near the top of the address space and a counter whose upper nibble is nonzero. Only these show wrap-around of the increment and the nibble carried into absolute jumps. The bench reaches them with register jumps to chosen addresses, such as 32'hFFFF_FFF8 and 32'hA000_0000, and then continues with sequential and absolute-jump steps. It sweeps both comparison codes over equal and unequal operands with displacements at both signed extremes. It covers all four low-bit patterns of a register target, and it repeats every code with `advance_i` low.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int CTRL_W = 3;

  typedef enum logic [CTRL_W-1:0] {
    NPC_SEQ  = 3'd0,
    NPC_BEQ  = 3'd1,
    NPC_BNE  = 3'd2,
    NPC_JMP  = 3'd3,
    NPC_JREG = 3'd4
  } npc_op_e;
endpackage

// File: rtl/npc_compare.sv
module npc_compare #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              eq_o
);
  logic [DATA_W-1:0] diff;

  assign diff = a_i ^ b_i;
  assign eq_o = ~|diff;
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int OFF_W = 16,
  parameter int IDX_W = 26
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              eq_i,
  input  logic [PC_W-1:0]   reg_tgt_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [IDX_W-1:0]  index_i,
  output logic [PC_W-1:0]   next_o,
  output logic              take_o,
  output logic              misal_o
);
  localparam int WSH  = 2;
  localparam int HI_W = PC_W - IDX_W - WSH;
  localparam int EXT  = PC_W - OFF_W - WSH;

  npc_op_e           op;
  logic [PC_W-1:0]   pc_plus;
  logic [PC_W-1:0]   disp;
  logic [PC_W-1:0]   br_tgt;
  logic [PC_W-1:0]   jmp_tgt;

  assign op      = npc_op_e'(ctrl_i);
  assign pc_plus = pc_i + PC_W'(4);
  assign disp    = {{EXT{offset_i[OFF_W-1]}}, offset_i, {WSH{1'b0}}};
  assign br_tgt  = pc_plus + disp;
  assign jmp_tgt = {pc_plus[PC_W-1 -: HI_W], index_i, {WSH{1'b0}}};

  always_comb begin
    next_o  = pc_plus;
    take_o  = 1'b0;
    misal_o = 1'b0;
    case (op)
      NPC_BEQ: if (eq_i) begin
        next_o = br_tgt;
        take_o = 1'b1;
      end
      NPC_BNE: if (!eq_i) begin
        next_o = br_tgt;
        take_o = 1'b1;
      end
      NPC_JMP: begin
        next_o = jmp_tgt;
        take_o = 1'b1;
      end
      NPC_JREG: begin
        next_o  = reg_tgt_i;
        take_o  = 1'b1;
        misal_o = |reg_tgt_i[WSH-1:0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int          PC_W      = 32,
  parameter int          OFF_W     = 16,
  parameter int          IDX_W     = 26,
  parameter logic [31:0] RESET_VEC = 32'h0000_1000
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              advance_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [PC_W-1:0]   opa_i,
  input  logic [PC_W-1:0]   opb_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [IDX_W-1:0]  index_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              taken_o,
  output logic              misalign_o
);
  logic            eq;
  logic [PC_W-1:0] nxt;
  logic            take_c;
  logic            misal_c;
  logic [PC_W-1:0] pc_q;
  logic            taken_q;
  logic            misal_q;

  npc_compare #(.DATA_W(PC_W)) u_cmp (
    .a_i (opa_i),
    .b_i (opb_i),
    .eq_o(eq)
  );

  npc_target #(.PC_W(PC_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_tgt (
    .pc_i     (pc_q),
    .ctrl_i   (ctrl_i),
    .eq_i     (eq),
    .reg_tgt_i(opa_i),
    .offset_i (offset_i),
    .index_i  (index_i),
    .next_o   (nxt),
    .take_o   (take_c),
    .misal_o  (misal_c)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pc_q    <= PC_W'(RESET_VEC);
      taken_q <= 1'b0;
      misal_q <= 1'b0;
    end else begin
      if (advance_i) pc_q <= nxt;
      taken_q <= advance_i & take_c;
      misal_q <= advance_i & misal_c;
    end
  end

  assign pc_o       = pc_q;
  assign taken_o    = taken_q;
  assign misalign_o = misal_q;

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    !advance_i |=> $stable(pc_q) && !taken_q && !misal_q);

  assert_seq_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (advance_i && ctrl_i == NPC_SEQ) |=> (pc_q == $past(pc_q) + PC_W'(4)) && !taken_q);

  assert_jump_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (advance_i && ctrl_i == NPC_JMP) |=> taken_q && (pc_q[IDX_W+1:0] == {$past(index_i), 2'b00}));

  assert_jreg_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (advance_i && ctrl_i == NPC_JREG) |=> taken_q && (pc_q == $past(opa_i)));

  assert_misal_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    misal_q |-> (pc_q[1:0] != 2'b00) && taken_q);

  assert_beq_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (advance_i && ctrl_i == NPC_BEQ && opa_i != opb_i) |=> !taken_q && (pc_q == $past(pc_q) + PC_W'(4)));
endmodule

// File: tb/test_npc_unit.sv
`timescale 1ns/1ps
module test_npc_unit;
  localparam real CYC = 20.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv = 1'b0;
  logic [2:0]  ctrl = 3'd0;
  logic [31:0] opa = '0, opb = '0;
  logic [15:0] off = '0;
  logic [25:0] idx = '0;
  logic [31:0] pc;
  logic        taken, misal;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] mpc;

  always #(CYC/2) clk = ~clk;

  npc_unit i_npc_unit (
    .clk_i(clk), .rst_i(rst), .advance_i(adv), .ctrl_i(ctrl),
    .opa_i(opa), .opb_i(opb), .offset_i(off), .index_i(idx),
    .pc_o(pc), .taken_o(taken), .misalign_o(misal)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b,
                      input logic [15:0] o, input logic [25:0] x, input logic en, input string req);
    logic [31:0] p4, nx;
    logic tk, ms;
    ctrl = c; opa = a; opb = b; off = o; idx = x; adv = en;
    p4 = mpc + 32'd4;
    nx = p4; tk = 0; ms = 0;
    case (c)
      3'd1: if (a == b) begin nx = p4 + 32'($signed(o) * 4); tk = 1; end
      3'd2: if (a != b) begin nx = p4 + 32'($signed(o) * 4); tk = 1; end
      3'd3: begin nx = {p4[31:28], x, 2'b00}; tk = 1; end
      3'd4: begin nx = a; tk = 1; ms = (a % 4) != 0; end
      default: ;
    endcase
    if (!en) begin nx = mpc; tk = 0; ms = 0; end
    @(posedge clk);
    @(negedge clk);
    chk(req, "pc", pc, nx);
    chk(req, "taken", {31'd0, taken}, {31'd0, tk});
    chk(req, "misalign", {31'd0, misal}, {31'd0, ms});
    mpc = nx;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] offs [7];
    offs = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h0005, 16'hFFFB};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "pc", pc, 32'h0000_1000);
    chk("R1", "taken", {31'd0, taken}, 32'd0);
    chk("R1", "misalign", {31'd0, misal}, 32'd0);
    rst = 0;
    mpc = 32'h0000_1000;

    // R2 sequential and undefined codes
    for (int c = 0; c < 8; c++)
      if (c == 0 || c > 4) step(3'(c), 32'h5, 32'h5, 16'h0010, 26'h3, 1'b1, "R2");

    // R3 / R4 / R9 comparison sweep
    for (int k = 0; k < 7; k++) begin
      step(3'd1, 32'hCAFE_0001, 32'hCAFE_0001, offs[k], '0, 1'b1, "R3");
      step(3'd1, 32'hCAFE_0001, 32'hCAFE_0003, offs[k], '0, 1'b1, "R3");
      step(3'd2, 32'h8000_0000, 32'h0000_0000, offs[k], '0, 1'b1, "R4");
      step(3'd2, 32'h1234_5678, 32'h1234_5678, offs[k], '0, 1'b1, "R4");
    end
    // R9 backward branch wrapping below zero
    step(3'd4, 32'h0000_0004, '0, '0, '0, 1'b1, "R6");
    step(3'd1, '0, '0, 16'h8000, '0, 1'b1, "R9");

    // R9 increment wrap at top of space
    step(3'd4, 32'hFFFF_FFF8, '0, '0, '0, 1'b1, "R6");
    for (int k = 0; k < 3; k++) step(3'd0, '0, '0, '0, '0, 1'b1, "R9");

    // R7 all low-bit patterns of a register target
    for (int lo = 0; lo < 4; lo++)
      step(3'd4, 32'h0040_0100 | 32'(lo), '0, '0, '0, 1'b1, "R7");
    step(3'd0, '0, '0, '0, '0, 1'b1, "R7");

    // R5 absolute jump with nonzero upper nibble
    step(3'd4, 32'hA000_0000, '0, '0, '0, 1'b1, "R6");
    for (int k = 0; k < 26; k++)
      step(3'd3, '0, '0, '0, 26'(1) << k, 1'b1, "R5");
    step(3'd3, '0, '0, '0, 26'h3FF_FFFF, 1'b1, "R5");
    step(3'd4, 32'hEFFF_FFFC, '0, '0, '0, 1'b1, "R6");
    step(3'd3, '0, '0, '0, 26'h15A_5A5A, 1'b1, "R5");

    // R8 advance low with every code
    for (int c = 0; c < 8; c++)
      step(3'(c), 32'h0000_0003, 32'h0000_0003, 16'h0040, 26'h77, 1'b0, "R8");
    step(3'd4, 32'h0000_0002, '0, '0, '0, 1'b0, "R8");

    // R1 reset again from a moved counter
    rst = 1;
    @(posedge clk); @(negedge clk);
    chk("R1", "pc", pc, 32'h0000_1000);
    chk("R1", "taken", {31'd0, taken}, 32'd0);
    rst = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule